// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status-Tagged Receive Queue

This block turns an asynchronous serial line into a queue of received characters. A one-cycle tick that fires sixteen times per bit period drives it. The frame can carry seven or eight data bits, least significant bit first. An optional parity bit follows, which can be odd or even. The frame ends with one or two stop bits. The receiver checks each finished frame for parity, framing and break conditions and writes it into a 32-deep queue. Each queue entry keeps its own error flags.

Software or a bus decoder reads the oldest entry as one 16-bit status-and-data word and pops it with a read strobe. Alongside the word, the block outputs a data-waiting flag, a programmable fill-threshold flag, full and empty indications, and a sticky break flag that is cleared by writing 1. A loopback control feeds the local transmit line into the receiver in place of the external line, for self-test.

Top module: `uart_rx_errfifo`

## Requirements
- R1: In 8-bit mode (cfg_eight=1), a frame with a low start bit, 8 data bits sent LSB first and a high stop bit is stored. Read as rd_word, it has bit 15 (valid) set, bits 14:8 clear and the character in bits 7:0.
- R2: In 7-bit mode (cfg_eight=0), only 7 data bits are taken from the line. Bit 7 of the stored character reads 0.
- R3: With cfg_par_en=1, one parity bit follows the data. The total count of 1s across data and parity must be odd when cfg_par_odd=1 and even when cfg_par_odd=0. A mismatch sets bit 10 of that entry.
- R4: A stop bit sampled low sets the framing flag, bit 12. With cfg_two_stop=1, both stop positions are sampled and either one being low sets it.
- R5: A frame whose line is low at every data, parity and stop sample is a break. Its entry has bits 11 and 12 set, and brk_flag rises. A pulse on brk_clr clears brk_flag, but a break arriving in the same cycle wins. After a low stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R6: The start bit is checked again at its half-bit point, eight ticks after the falling edge. If the line is high by then, the start bit is dropped and nothing is stored.
- R7: The queue holds 32 entries and returns them in arrival order. fifo_empty, fifo_full and data_rdy (meaning at least one entry is waiting) follow the fill level, and full and empty are never both set.
- R8: A frame that completes while the queue is full is discarded. Instead, the most recently stored entry gets its overrun flag, bit 13, set.
- R9: Bit 14 of a valid read word equals the OR of bits 13, 12, 11 and 10 of the same entry.
- R10: The fill threshold is loaded from trig_wdata when trig_we=1 and resets to 1. trig_hit is high while the number of stored entries is greater than or equal to the threshold.
- R11: With loop_en=1, the receiver takes its input from tx_line, and rx_line has no effect.
- R12: When the queue is empty, rd_word reads 0. A read strobe then leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| rx_line | input | 1 | External serial input, idle high |
| tx_line | input | 1 | Local transmit line used in loopback |
| loop_en | input | 1 | Selects tx_line as the receiver input |
| cfg_eight | input | 1 | 1: eight data bits, 0: seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| trig_we | input | 1 | Load strobe for the fill threshold |
| trig_wdata | input | 6 | New fill threshold |
| rd_en | input | 1 | Pops the oldest entry |
| rd_word | output | 16 | Oldest entry as a status-and-data word |
| data_rdy | output | 1 | At least one entry waiting |
| trig_hit | output | 1 | Fill level at or above threshold |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| brk_flag | output | 1 | Sticky break indication |
| brk_clr | input | 1 | Write-1 clear for brk_flag |

## Verification
The properties assume three things about the inputs. The frame-format controls stay still while a frame is on the line. tick16 is a single-cycle pulse with at least a few clocks between pulses, so the two-stage input synchronizer settles before each sample. rd_en is a single-cycle strobe. The stimulus respects all three. It changes the format only while the line idles high, spaces ticks four clocks apart, and drives the line and strobes at the falling clock edge. Each bit is held for exactly sixteen ticks, so every mid-bit sample lands well inside the bit.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP1,
        S_STOP2,
        S_WAITHI
    } rx_state_e;

    // one finished frame as produced by the deserializer
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] chr;
    } rx_frame_t;

    // one queue slot; err is kept in step with the flag bits
    typedef struct packed {
        logic       err;
        logic       ovr;
        logic       frm;
        logic       brk;
        logic       par;
        logic [7:0] chr;
    } q_entry_t;

endpackage

// File: rtl/uartrx_frame.sv
module uartrx_frame
    import uartrx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic      cfg_eight,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      cfg_two_stop,
    output logic      frm_valid,
    output rx_frame_t frm
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    typedef struct packed {
        rx_state_e st;
        logic [CW-1:0] cnt;
        logic [2:0] idx;
        logic [7:0] data;
        logic parerr;
        logic frmerr;
        logic allzero;
        logic valid;
        rx_frame_t out;
    } fr_st_t;

    fr_st_t s_d, s_q;
    logic   mid, fin;
    logic [2:0] last_idx;

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        fin      = 1'b0;
        last_idx = cfg_eight ? 3'd7 : 3'd6;
        mid      = (s_q.cnt == CW'(OSR - 1));
        if (tick) begin
            case (s_q.st)
                S_IDLE: begin
                    if (!line) begin
                        s_d.st  = S_START;
                        s_d.cnt = '0;
                    end
                end
                S_START: begin
                    if (s_q.cnt == CW'(HALF - 2)) begin
                        s_d.cnt = '0;
                        if (line) begin
                            s_d.st = S_IDLE;
                        end else begin
                            s_d.st      = S_DATA;
                            s_d.idx     = '0;
                            s_d.data    = '0;
                            s_d.parerr  = 1'b0;
                            s_d.frmerr  = 1'b0;
                            s_d.allzero = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (mid) begin
                        s_d.cnt            = '0;
                        s_d.data[s_q.idx]  = line;
                        if (line) s_d.allzero = 1'b0;
                        if (s_q.idx == last_idx)
                            s_d.st = cfg_par_en ? S_PAR : S_STOP1;
                        else
                            s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (mid) begin
                        s_d.cnt    = '0;
                        if (line) s_d.allzero = 1'b0;
                        s_d.parerr = ((^s_q.data) ^ line) != cfg_par_odd;
                        s_d.st     = S_STOP1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_STOP1, S_STOP2: begin
                    if (mid) begin
                        s_d.cnt = '0;
                        if (line) s_d.allzero = 1'b0;
                        else      s_d.frmerr  = 1'b1;
                        if (s_q.st == S_STOP1 && cfg_two_stop) s_d.st = S_STOP2;
                        else                                   fin = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_WAITHI: begin
                    if (line) s_d.st = S_IDLE;
                end
                default: s_d.st = S_IDLE;
            endcase
        end
        if (fin) begin
            s_d.valid = 1'b1;
            s_d.out   = '{brk: s_d.allzero, frm: s_d.frmerr,
                          par: s_d.parerr, chr: s_d.data};
            s_d.st    = line ? S_IDLE : S_WAITHI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign frm_valid = s_q.valid;
    assign frm       = s_q.out;

endmodule

// File: rtl/uartrx_fifo.sv
module uartrx_fifo
    import uartrx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_frame_t     push_data,
    input  logic          pop,
    output q_entry_t      head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_st_t;

    q_st_t    s_d, s_q;
    q_entry_t mem_d [DEPTH];
    q_entry_t mem_q [DEPTH];
    logic     do_push, do_pop, is_full;
    logic [AW-1:0] last;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        mem_d   = mem_q;
        is_full = (s_q.cnt == CW'(DEPTH));
        do_push = push && !is_full;
        do_pop  = pop && (s_q.cnt != '0);
        last    = (s_q.wp == '0) ? AW'(DEPTH - 1) : s_q.wp - 1'b1;
        if (do_push) begin
            mem_d[s_q.wp] = '{err: push_data.brk | push_data.frm | push_data.par,
                              ovr: 1'b0, frm: push_data.frm, brk: push_data.brk,
                              par: push_data.par, chr: push_data.chr};
            s_d.wp = wrap_inc(s_q.wp);
        end else if (push) begin
            // no room: tag the newest stored entry instead
            mem_d[last].ovr = 1'b1;
            mem_d[last].err = 1'b1;
        end
        if (do_pop) s_d.rp = wrap_inc(s_q.rp);
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign head  = mem_q[s_q.rp];
    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import uartrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 32,
    localparam int TLW  = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick16,
    input  logic           rx_line,
    input  logic           tx_line,
    input  logic           loop_en,
    input  logic           cfg_eight,
    input  logic           cfg_par_en,
    input  logic           cfg_par_odd,
    input  logic           cfg_two_stop,
    input  logic           trig_we,
    input  logic [TLW-1:0] trig_wdata,
    input  logic           rd_en,
    output logic [15:0]    rd_word,
    output logic           data_rdy,
    output logic           trig_hit,
    output logic           fifo_empty,
    output logic           fifo_full,
    output logic           brk_flag,
    input  logic           brk_clr
);
    typedef struct packed {
        logic [1:0]     sync;
        logic [TLW-1:0] trig;
        logic           brk;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic           fr_valid;
    rx_frame_t      fr_data;
    logic           fr_is_brk;
    q_entry_t       head;
    logic [TLW-1:0] fill;
    logic           q_empty, q_full;
    logic [TLW-1:0] trig_lvl_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], loop_en ? tx_line : rx_line};
        if (trig_we) st_d.trig = trig_wdata;
        if (brk_clr) st_d.brk = 1'b0;
        if (fr_valid && fr_data.brk) st_d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 2'b11;
            st_q.trig <= TLW'(1);
            st_q.brk  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    uartrx_frame #(.OSR(OSR)) i_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .line         (st_q.sync[1]),
        .cfg_eight    (cfg_eight),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .frm_valid    (fr_valid),
        .frm          (fr_data)
    );

    uartrx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fr_valid),
        .push_data (fr_data),
        .pop       (rd_en),
        .head      (head),
        .count     (fill),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign fr_is_brk  = fr_data.brk;
    assign trig_lvl_q = st_q.trig;
    assign rd_word    = q_empty ? 16'h0000 :
                        {1'b1, head.err, head.ovr, head.frm, head.brk, head.par,
                         2'b00, head.chr};
    assign data_rdy   = !q_empty;
    assign trig_hit   = (fill >= st_q.trig);
    assign fifo_empty = q_empty;
    assign fifo_full  = q_full;
    assign brk_flag   = st_q.brk;

endmodule

// File: rtl/uartrx_chk.sv
module uartrx_chk #(
    parameter int TLW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_en,
    input logic [15:0]    rd_word,
    input logic           fifo_empty,
    input logic           fifo_full,
    input logic           trig_hit,
    input logic [TLW-1:0] trig_lvl,
    input logic           brk_flag,
    input logic           brk_clr,
    input logic           fr_valid,
    input logic           fr_is_brk
);
    // R7
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R12
    empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (rd_word == 16'h0000));

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !fr_valid) |=> fifo_empty);

    // R9
    err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[15] |-> (rd_word[14] == (|rd_word[13:10])));

    // R5
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_is_brk) |=> brk_flag);

    // R5
    brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !(fr_valid && fr_is_brk)) |=> !brk_flag);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !rd_en) |=> fifo_full);

    // R10
    trig_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && trig_lvl != '0) |-> !trig_hit);

endmodule

bind uart_rx_errfifo uartrx_chk #(.TLW(TLW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_word    (rd_word),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .trig_hit   (trig_hit),
    .trig_lvl   (trig_lvl_q),
    .brk_flag   (brk_flag),
    .brk_clr    (brk_clr),
    .fr_valid   (fr_valid),
    .fr_is_brk  (fr_is_brk)
);

// File: tb/test_uart_rx_errfifo.sv
module test_uart_rx_errfifo;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int NV = 10;

    // cfg = {eight, par_en, odd, two_stop}; stops = {first, second}
    typedef struct packed {
        logic [3:0]  cfg;
        logic [7:0]  d;
        logic        flip;
        logic [1:0]  stops;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'b1000, 8'hA5, 1'b0, 2'b11, 16'h80A5},
        '{4'b1000, 8'h00, 1'b0, 2'b11, 16'h8000},
        '{4'b0000, 8'hFF, 1'b0, 2'b11, 16'h807F},
        '{4'b1100, 8'h3C, 1'b0, 2'b11, 16'h803C},
        '{4'b1110, 8'h3C, 1'b0, 2'b11, 16'h803C},
        '{4'b1100, 8'h3C, 1'b1, 2'b11, 16'hC43C},
        '{4'b0111, 8'h55, 1'b0, 2'b11, 16'h8055},
        '{4'b1000, 8'h81, 1'b0, 2'b01, 16'hD081},
        '{4'b1001, 8'h12, 1'b0, 2'b10, 16'hD012},
        '{4'b1100, 8'h00, 1'b0, 2'b00, 16'hD800}
    };
    localparam string TAGS [NV] = '{"R1", "R1", "R2", "R3", "R3",
                                    "R3", "R2", "R4", "R4", "R5"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] tdiv = '0;
    logic       rx_line = 1'b1;
    logic       tx_line = 1'b1;
    logic       loop_en = 1'b0;
    logic       cfg_eight = 1'b1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       trig_we = 1'b0;
    logic [5:0] trig_wdata = '0;
    logic       rd_en = 1'b0;
    logic       brk_clr = 1'b0;
    logic       use_lb = 1'b0;
    logic [15:0] rd_word;
    logic       data_rdy, trig_hit, fifo_empty, fifo_full, brk_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 1'b1;
        tick16 <= (tdiv == 2'(TDIV - 1));
    end

    uart_rx_errfifo i_uart_rx_errfifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .rx_line      (rx_line),
        .tx_line      (tx_line),
        .loop_en      (loop_en),
        .cfg_eight    (cfg_eight),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .trig_we      (trig_we),
        .trig_wdata   (trig_wdata),
        .rd_en        (rd_en),
        .rd_word      (rd_word),
        .data_rdy     (data_rdy),
        .trig_hit     (trig_hit),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .brk_flag     (brk_flag),
        .brk_clr      (brk_clr)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic drive(input logic v);
        if (use_lb) tx_line = v;
        else        rx_line = v;
    endtask

    task automatic send_frame(input logic [3:0] cfg, input logic [7:0] d,
                              input logic flip, input logic [1:0] stops);
        logic [7:0] m;
        @(negedge clk);
        {cfg_eight, cfg_par_en, cfg_par_odd, cfg_two_stop} = cfg;
        m = cfg[3] ? d : (d & 8'h7F);
        drive(1'b0);
        wait_ticks(16);
        for (int i = 0; i < (cfg[3] ? 8 : 7); i++) begin
            drive(d[i]);
            wait_ticks(16);
        end
        if (cfg[2]) begin
            drive((^m) ^ cfg[1] ^ flip);
            wait_ticks(16);
        end
        drive(stops[1]);
        wait_ticks(16);
        if (cfg[0]) begin
            drive(stops[0]);
            wait_ticks(16);
        end
        drive(1'b1);
        wait_ticks(32);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R7 R10 R12
        check("R7 reset empty", {15'd0, fifo_empty}, 16'd1);
        check("R7 reset full", {15'd0, fifo_full}, 16'd0);
        check("R7 reset data_rdy", {15'd0, data_rdy}, 16'd0);
        check("R12 reset word", rd_word, 16'h0000);
        check("R10 reset trig_hit", {15'd0, trig_hit}, 16'd0);
        check("R5 reset brk", {15'd0, brk_flag}, 16'd0);

        // table of frame formats
        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v].cfg, VECS[v].d, VECS[v].flip, VECS[v].stops);
            check({TAGS[v], " data_rdy"}, {15'd0, data_rdy}, 16'd1);
            check({TAGS[v], " word"}, rd_word, VECS[v].exp);
            pop_one();
            check({TAGS[v], " drained"}, {15'd0, fifo_empty}, 16'd1);
        end

        // R5 sticky break and write-1 clear
        check("R5 brk sticky", {15'd0, brk_flag}, 16'd1);
        @(negedge clk);
        brk_clr = 1'b1;
        @(negedge clk);
        brk_clr = 1'b0;
        check("R5 brk cleared", {15'd0, brk_flag}, 16'd0);

        // R6 short low pulse is not a start bit
        @(negedge clk);
        rx_line = 1'b0;
        wait_ticks(4);
        rx_line = 1'b1;
        wait_ticks(40);
        check("R6 glitch ignored", {15'd0, fifo_empty}, 16'd1);

        // R12 read strobe on empty queue
        pop_one();
        check("R12 empty read word", rd_word, 16'h0000);
        send_frame(4'b1000, 8'h11, 1'b0, 2'b11);
        check("R12 order after empty read", rd_word, 16'h8011);
        check("R10 default level hit", {15'd0, trig_hit}, 16'd1);
        pop_one();

        // R10 programmed threshold
        @(negedge clk);
        trig_we = 1'b1;
        trig_wdata = 6'd3;
        @(negedge clk);
        trig_we = 1'b0;
        send_frame(4'b1000, 8'h21, 1'b0, 2'b11);
        send_frame(4'b1000, 8'h22, 1'b0, 2'b11);
        check("R10 below level", {15'd0, trig_hit}, 16'd0);
        send_frame(4'b1000, 8'h23, 1'b0, 2'b11);
        check("R10 at level", {15'd0, trig_hit}, 16'd1);
        repeat (3) pop_one();

        // R7 R8 fill, overflow, drain
        for (int i = 0; i < 32; i++) send_frame(4'b1000, 8'(i), 1'b0, 2'b11);
        check("R7 full at 32", {15'd0, fifo_full}, 16'd1);
        send_frame(4'b1000, 8'hEE, 1'b0, 2'b11);
        check("R8 still full", {15'd0, fifo_full}, 16'd1);
        for (int i = 0; i < 32; i++) begin
            check(i == 31 ? "R8 overrun on newest" : "R7 order",
                  rd_word, (i == 31) ? 16'hE01F : (16'h8000 | 16'(i)));
            pop_one();
        end
        check("R8 empty after drain", {15'd0, fifo_empty}, 16'd1);

        // R11 loopback
        @(negedge clk);
        loop_en = 1'b1;
        use_lb = 1'b1;
        rx_line = 1'b0;
        wait_ticks(20);
        send_frame(4'b1000, 8'h5A, 1'b0, 2'b11);
        check("R11 loopback word", rd_word, 16'h805A);
        pop_one();
        check("R11 loopback only one", {15'd0, fifo_empty}, 16'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule